// File: doc/BRIEF.md
# Configurable Memory Data Checker with Single-Error Correction

This block protects a 16-bit memory data word with a 6-bit check field. Software selects one of three modes through a small control write port. In the Hamming mode, five position-coded check bits and one overall parity bit correct any single flipped bit and detect any two flipped bits. In the parity mode, one check bit carries even or odd parity. In the off mode, nothing is checked or generated, and this is the mode after reset.

On a memory write, the block drives a check field computed from the write data in the same data phase. On a memory read, it compares the received data and check bits and raises an active-low error for uncorrectable or parity errors. It raises an active-high single-error flag for corrected words, which is enabled only in the Hamming mode. It also keeps the corrected word. That corrected word is driven back one clock after the external memory is told to release the data lines. The block records the address of the first failing read until software clears it.

Top module: `mem_edac`

## Requirements
- R1: After reset, the mode is off. `mem_err_no` is 1, and `sing_err_oe_o`, `data_oe_o`, `chk_oe_o` and `fail_valid_o` are 0.
- R2: A control write (`cfg_we_i`) takes effect from the next clock. `cfg_wdata_i[1:0]` selects the mode: 00 off, 01 parity, 10 Hamming, and 11 off. `cfg_wdata_i[2]` selects odd parity (1) or even parity (0).
- R3: In the Hamming mode, data bit k sits at the k-th codeword position, counting upward from 3 and skipping powers of two (3,5,6,7,9,…,21). For i in 0..4, check bit i is the XOR of the data bits whose position has bit i set. Check bit 5 is the XOR of all 16 data bits and check bits 0..4. `chk_o` carries this field during a memory write.
- R4: In the parity mode, `chk_o[0]` is the XOR of the data in even mode and its inverse in odd mode, and `chk_o[5:1]` is 0. `chk_oe_o` is 1 only during a memory write (`cyc_valid_i`, `cyc_mem_i` and `cyc_write_i` all high) with a mode other than off.
- R5: On a Hamming memory read, two cases are error-free: a word with no flipped bit gives no error, and a word with exactly one flipped bit among the 22 gives `sing_err_o`=1 with `mem_err_no`=1. In both cases the corrected data equals the written data.
- R6: On a Hamming memory read with two flipped bits, `mem_err_no` is 0 and `sing_err_o` is 0.
- R7: On a parity-mode memory read, `mem_err_no` is 0 exactly when the XOR of `data_i`, `chk_i[0]` and the odd-select bit is 1.
- R8: I/O cycles, write cycles and the off mode never drive `mem_err_no` low or `sing_err_o` high. `sing_err_oe_o` is 1 exactly while the Hamming mode is selected.
- R9: `data_oe_o` is 1 in the clock after one in which `ram_dis_i` was sampled high with the Hamming mode selected. `data_o` holds the corrected data of the most recent Hamming memory read.
- R10: The first failing read after a clear loads `fail_addr_o` with its address and sets `fail_valid_o`. A failing read is a single error, a multiple error or a parity error. Later failing reads leave the address unchanged. A control write with `cfg_wdata_i[3]`=1 clears `fail_valid_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Control register write strobe |
| cfg_wdata_i | input | 4 | Mode, odd-parity select, clear-failure bit |
| cyc_valid_i | input | 1 | Data phase of a bus cycle is active |
| cyc_mem_i | input | 1 | 1 for memory cycle, 0 for I/O |
| cyc_write_i | input | 1 | 1 for write, 0 for read |
| addr_i | input | 20 | Address of the current cycle |
| data_i | input | 16 | Data on the bus |
| chk_i | input | 6 | Check bits read from memory |
| ram_dis_i | input | 1 | Memory has released the data lines |
| chk_o | output | 6 | Generated check bits |
| chk_oe_o | output | 1 | Drive enable for `chk_o` |
| mem_err_no | output | 1 | Uncorrectable or parity error, active low |
| sing_err_o | output | 1 | Single error corrected |
| sing_err_oe_o | output | 1 | Drive enable for `sing_err_o` |
| data_o | output | 16 | Corrected data register |
| data_oe_o | output | 1 | Drive enable for `data_o` |
| fail_addr_o | output | 20 | Address of first failing read |
| fail_valid_o | output | 1 | `fail_addr_o` holds a captured address |

## Verification
The bench sweeps a set of data words through the Hamming mode. For each word it checks the generated field, a clean read, every one of the 22 single flips and, for some words, all 231 double flips. A wrong bit position would miscorrect some single flip or report it as a multiple error. A missing overall bit would call double flips single. In the parity mode the bench tests both polarities, so an inverted polarity shows up at once. It also tests I/O reads and off-mode reads with corrupt words, which catches a design that checks every cycle. The first-failure register is hit with repeated errors and a clear, which exposes a register that overwrites on each error.

// File: rtl/edac_pkg.sv
package edac_pkg;
  typedef enum logic [1:0] {
    MODE_OFF = 2'b00,
    MODE_PAR = 2'b01,
    MODE_HAM = 2'b10
  } mode_e;

  // Smallest h with 2^h >= dw + h + 1.
  function automatic int ham_bits(int dw);
    for (int h = 1; h < 31; h++)
      if ((1 << h) >= dw + h + 1) return h;
    return 31;
  endfunction

  // Codeword position of data bit k: k-th non-power-of-two from 3 upward.
  function automatic int data_pos(int k);
    int n;
    n = 0;
    for (int q = 3; q < 4096; q++) begin
      if ((q & (q - 1)) != 0) begin
        if (n == k) return q;
        n++;
      end
    end
    return 0;
  endfunction
endpackage

// File: rtl/edac_enc.sv
module edac_enc #(
  parameter int DATA_W = 16,
  parameter int HAM_W  = 5
) (
  input  logic [DATA_W-1:0] data_i,
  output logic [HAM_W-1:0]  ham_o,
  output logic              ovr_o
);
  for (genvar i = 0; i < HAM_W; i++) begin : g_chk
    logic [DATA_W-1:0] sel;
    for (genvar k = 0; k < DATA_W; k++) begin : g_bit
      localparam int P = edac_pkg::data_pos(k);
      assign sel[k] = data_i[k] & P[i];
    end
    assign ham_o[i] = ^sel;
  end

  assign ovr_o = ^data_i ^ ^ham_o;
endmodule

// File: rtl/edac_dec.sv
module edac_dec #(
  parameter int DATA_W = 16,
  parameter int HAM_W  = 5
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [HAM_W:0]    chk_i,
  input  logic [HAM_W-1:0]  ham_calc_i,
  output logic              single_o,
  output logic              multi_o,
  output logic [DATA_W-1:0] data_o
);
  localparam logic [HAM_W-1:0] LAST_POS = HAM_W'(DATA_W + HAM_W);

  logic [HAM_W-1:0] syn;
  logic             ovr;

  assign syn = ham_calc_i ^ chk_i[HAM_W-1:0];
  assign ovr = ^{data_i, chk_i};

  // Odd overall parity with a syndrome inside the codeword: one flip.
  assign single_o = ovr && (syn <= LAST_POS);
  assign multi_o  = (!ovr && syn != '0) || (ovr && syn > LAST_POS);

  for (genvar k = 0; k < DATA_W; k++) begin : g_fix
    localparam int P = edac_pkg::data_pos(k);
    assign data_o[k] = data_i[k] ^ (ovr && syn == P[HAM_W-1:0]);
  end
endmodule

// File: rtl/edac_diag.sv
module edac_diag #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_ham_i,
  input  logic              err_i,
  input  logic              clr_i,
  input  logic              drv_req_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] corr_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  output logic [ADDR_W-1:0] fail_addr_o,
  output logic              fail_valid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o       <= '0;
      data_oe_o    <= 1'b0;
      fail_addr_o  <= '0;
      fail_valid_o <= 1'b0;
    end else begin
      data_oe_o <= drv_req_i;
      if (rd_ham_i) data_o <= corr_i;
      // An error in the same cycle as a clear is recorded.
      if (err_i && (!fail_valid_o || clr_i)) begin
        fail_addr_o  <= addr_i;
        fail_valid_o <= 1'b1;
      end else if (clr_i) begin
        fail_valid_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/mem_edac.sv
module mem_edac
  import edac_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 20,
  localparam int HAM_W = ham_bits(DATA_W),
  localparam int CHK_W = HAM_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [3:0]        cfg_wdata_i,
  input  logic              cyc_valid_i,
  input  logic              cyc_mem_i,
  input  logic              cyc_write_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [CHK_W-1:0]  chk_i,
  input  logic              ram_dis_i,
  output logic [CHK_W-1:0]  chk_o,
  output logic              chk_oe_o,
  output logic              mem_err_no,
  output logic              sing_err_o,
  output logic              sing_err_oe_o,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  output logic [ADDR_W-1:0] fail_addr_o,
  output logic              fail_valid_o
);
  mode_e mode_q;
  logic  odd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_OFF;
      odd_q  <= 1'b0;
    end else if (cfg_we_i) begin
      unique case (cfg_wdata_i[1:0])
        2'b01:   mode_q <= MODE_PAR;
        2'b10:   mode_q <= MODE_HAM;
        default: mode_q <= MODE_OFF;
      endcase
      odd_q <= cfg_wdata_i[2];
    end
  end

  logic              ham_en, par_en, rd_cyc, wr_cyc;
  logic [HAM_W-1:0]  ham_calc;
  logic              ovr_calc, single, multi, par_err;
  logic [DATA_W-1:0] corr;

  assign ham_en = (mode_q == MODE_HAM);
  assign par_en = (mode_q == MODE_PAR);
  assign rd_cyc = cyc_valid_i && cyc_mem_i && !cyc_write_i;
  assign wr_cyc = cyc_valid_i && cyc_mem_i && cyc_write_i;

  edac_enc #(.DATA_W(DATA_W), .HAM_W(HAM_W)) u_enc (
    .data_i (data_i),
    .ham_o  (ham_calc),
    .ovr_o  (ovr_calc)
  );

  edac_dec #(.DATA_W(DATA_W), .HAM_W(HAM_W)) u_dec (
    .data_i     (data_i),
    .chk_i      (chk_i),
    .ham_calc_i (ham_calc),
    .single_o   (single),
    .multi_o    (multi),
    .data_o     (corr)
  );

  assign par_err = ^data_i ^ chk_i[0] ^ odd_q;

  always_comb begin
    chk_o = '0;
    if (ham_en)      chk_o = {ovr_calc, ham_calc};
    else if (par_en) chk_o[0] = ^data_i ^ odd_q;
  end

  assign chk_oe_o      = wr_cyc && (ham_en || par_en);
  assign mem_err_no    = !(rd_cyc && ((ham_en && multi) || (par_en && par_err)));
  assign sing_err_o    = rd_cyc && ham_en && single;
  assign sing_err_oe_o = ham_en;

  edac_diag #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_diag (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rd_ham_i     (rd_cyc && ham_en),
    .err_i        (rd_cyc && ((ham_en && (single || multi)) || (par_en && par_err))),
    .clr_i        (cfg_we_i && cfg_wdata_i[3]),
    .drv_req_i    (ham_en && ram_dis_i),
    .addr_i       (addr_i),
    .corr_i       (corr),
    .data_o       (data_o),
    .data_oe_o    (data_oe_o),
    .fail_addr_o  (fail_addr_o),
    .fail_valid_o (fail_valid_o)
  );
endmodule

// File: rtl/edac_chk.sv
module edac_chk #(
  parameter int ADDR_W = 20
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [1:0]        mode_q,
  input logic              cfg_we_i,
  input logic [3:0]        cfg_wdata_i,
  input logic              cyc_mem_i,
  input logic              cyc_write_i,
  input logic              ram_dis_i,
  input logic              chk_oe_o,
  input logic              mem_err_no,
  input logic              sing_err_o,
  input logic              sing_err_oe_o,
  input logic              data_oe_o,
  input logic [ADDR_W-1:0] fail_addr_o,
  input logic              fail_valid_o
);
  assert_off_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == 2'b00) |-> (mem_err_no && !sing_err_oe_o));

  assert_sing_needs_oe_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sing_err_o |-> sing_err_oe_o);

  assert_err_exclusive_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sing_err_o && !mem_err_no));

  assert_drive_delay_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> $past(ram_dis_i));

  assert_fail_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(fail_valid_o) && !$past(cfg_we_i && cfg_wdata_i[3])) |-> ($stable(fail_addr_o) && fail_valid_o));

  assert_chk_oe_write_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_oe_o |-> (cyc_write_i && cyc_mem_i));
endmodule

bind mem_edac edac_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .mode_q        (mode_q),
  .cfg_we_i      (cfg_we_i),
  .cfg_wdata_i   (cfg_wdata_i),
  .cyc_mem_i     (cyc_mem_i),
  .cyc_write_i   (cyc_write_i),
  .ram_dis_i     (ram_dis_i),
  .chk_oe_o      (chk_oe_o),
  .mem_err_no    (mem_err_no),
  .sing_err_o    (sing_err_o),
  .sing_err_oe_o (sing_err_oe_o),
  .data_oe_o     (data_oe_o),
  .fail_addr_o   (fail_addr_o),
  .fail_valid_o  (fail_valid_o)
);

// File: tb/sim_mem_edac.sv
module sim_mem_edac;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [3:0]  cfg_wdata_i = '0;
  logic        cyc_valid_i = 1'b0, cyc_mem_i = 1'b0, cyc_write_i = 1'b0;
  logic [19:0] addr_i = '0;
  logic [15:0] data_i = '0;
  logic [5:0]  chk_i = '0;
  logic        ram_dis_i = 1'b0;
  logic [5:0]  chk_o;
  logic        chk_oe_o, mem_err_no, sing_err_o, sing_err_oe_o, data_oe_o, fail_valid_o;
  logic [15:0] data_o;
  logic [19:0] fail_addr_o;

  always #4 clk_i = ~clk_i;

  mem_edac u0 (.*);

  int n_chk = 0, n_fail = 0;
  logic s_err_n, s_sing, s_chkoe;
  logic [5:0] s_chk;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] ref_chk(input logic [15:0] d);
    logic [31:0] cw;
    logic [5:0]  c;
    int n;
    cw = '0; n = 0; c = '0;
    for (int p = 1; p <= 21; p++)
      if ((p & (p - 1)) != 0) begin cw[p] = d[n]; n++; end
    for (int i = 0; i < 5; i++)
      for (int p = 1; p <= 21; p++)
        if (p[i]) c[i] ^= cw[p];
    c[5] = ^d ^ ^c[4:0];
    return c;
  endfunction

  task automatic cfg(input logic [3:0] v);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_wdata_i = v;
    @(posedge clk_i); #1;
    cfg_we_i = 1'b0;
  endtask

  // One bus cycle: comb outputs sampled mid-cycle, registers after the edge.
  task automatic bus(input logic mem, input logic wr, input logic [19:0] a,
                     input logic [15:0] d, input logic [5:0] c, input logic rd_dis);
    @(negedge clk_i);
    cyc_valid_i = 1'b1; cyc_mem_i = mem; cyc_write_i = wr;
    addr_i = a; data_i = d; chk_i = c; ram_dis_i = rd_dis;
    #2;
    s_err_n = mem_err_no; s_sing = sing_err_o; s_chk = chk_o; s_chkoe = chk_oe_o;
    @(posedge clk_i); #1;
    cyc_valid_i = 1'b0; ram_dis_i = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    check(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] d;
    logic [5:0]  c;
    logic [21:0] cw;
    #20 rst_ni = 1'b1;
    @(negedge clk_i);
    check(mem_err_no == 1'b1, "R1 mem_err_no", mem_err_no, 1);
    check(sing_err_oe_o == 1'b0, "R1 sing_err_oe_o", sing_err_oe_o, 0);
    check(data_oe_o == 1'b0, "R1 data_oe_o", data_oe_o, 0);
    check(fail_valid_o == 1'b0, "R1 fail_valid_o", fail_valid_o, 0);
    check(chk_oe_o == 1'b0, "R1 chk_oe_o", chk_oe_o, 0);

    // Off mode: corrupt reads and writes produce nothing (R8, R4).
    bus(1, 0, 20'h10, 16'h0001, 6'h00, 1'b1);
    check(s_err_n == 1'b1 && s_sing == 1'b0, "R8 off read", {s_err_n, s_sing}, 2);
    check(data_oe_o == 1'b0, "R8 off no drive", data_oe_o, 0);
    bus(1, 1, 20'h11, 16'h1234, 6'h00, 1'b0);
    check(s_chkoe == 1'b0, "R4 off no chk_oe", s_chkoe, 0);

    // Parity modes.
    for (int odd = 0; odd < 2; odd++) begin
      cfg({1'b1, odd[0], 2'b01});
      check(fail_valid_o == 1'b0, "R10 clear", fail_valid_o, 0);
      check(sing_err_oe_o == 1'b0, "R8 parity oe", sing_err_oe_o, 0);
      for (int w = 0; w < 24; w++) begin
        d = 16'(w * 40503 + 777);
        bus(1, 1, 20'h100, d, 6'h00, 1'b0);
        check(s_chkoe && s_chk == {5'b0, ^d ^ odd[0]}, "R4 parity gen", s_chk, {5'b0, ^d ^ odd[0]});
        bus(1, 0, 20'h200, d, {5'h1f, ^d ^ odd[0]}, 1'b0);
        check(s_err_n == 1'b1, "R7 parity good", s_err_n, 1);
        bus(1, 0, 20'h12345 + 20'(w), d, {5'h00, ~(^d ^ odd[0])}, 1'b0);
        check(s_err_n == 1'b0 && s_sing == 1'b0, "R7 parity bad", s_err_n, 0);
        check(fail_valid_o && fail_addr_o == 20'h12345, "R10 first fail held", fail_addr_o, 20'h12345);
        bus(0, 0, 20'h300, d, {5'h00, ~(^d ^ odd[0])}, 1'b0);
        check(s_err_n == 1'b1, "R8 io ignored", s_err_n, 1);
      end
    end
    cfg(4'b1001);
    bus(1, 0, 20'h0F0F0, 16'h0003, 6'h01, 1'b0);
    check(fail_valid_o && fail_addr_o == 20'h0F0F0, "R10 recapture", fail_addr_o, 20'h0F0F0);

    // Mode 11 behaves as off (R2).
    cfg(4'b0011);
    bus(1, 0, 20'h1, 16'h0001, 6'h00, 1'b0);
    check(s_err_n == 1'b1 && sing_err_oe_o == 1'b0, "R2 mode 11 off", s_err_n, 1);

    // Hamming sweep.
    cfg(4'b1010);
    check(sing_err_oe_o == 1'b1, "R8 ham oe", sing_err_oe_o, 1);
    for (int w = 0; w < 40; w++) begin
      d = (w == 0) ? 16'h0000 : (w == 1) ? 16'hFFFF : (w < 18) ? (16'h1 << (w - 2)) : 16'(w * 40503 + 12345);
      c = ref_chk(d);
      bus(1, 1, 20'(w * 64), d, 6'h00, 1'b0);
      check(s_chkoe && s_chk == c, "R3 ham gen", s_chk, c);
      bus(1, 0, 20'(w * 64), d, c, 1'b1);
      check(s_err_n && !s_sing, "R5 clean read", {s_err_n, s_sing}, 2);
      check(data_oe_o && data_o == d, "R9 clean drive", data_o, d);
      for (int j = 0; j < 22; j++) begin
        cw = {c, d};
        cw[j] = ~cw[j];
        bus(1, 0, 20'(w * 64 + j + 1), cw[15:0], cw[21:16], 1'b1);
        check(s_err_n && s_sing, "R5 single flagged", {s_err_n, s_sing}, 3);
        check(data_oe_o && data_o == d, "R5 R9 corrected", data_o, d);
      end
      if (w < 4) begin
        for (int j = 0; j < 22; j++)
          for (int k = j + 1; k < 22; k++) begin
            cw = {c, d};
            cw[j] = ~cw[j]; cw[k] = ~cw[k];
            bus(1, 0, 20'h80000, cw[15:0], cw[21:16], 1'b0);
            check(!s_err_n && !s_sing, "R6 double", {s_err_n, s_sing}, 0);
            check(!data_oe_o, "R9 no drive", data_oe_o, 0);
          end
      end
      cw = {c, d}; cw[0] = ~cw[0]; cw[1] = ~cw[1];
      bus(0, 0, 20'h3, cw[15:0], cw[21:16], 1'b0);
      check(s_err_n && !s_sing, "R8 ham io ignored", {s_err_n, s_sing}, 2);
    end
    check(fail_valid_o && fail_addr_o == 20'h1, "R10 ham first fail", fail_addr_o, 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule